// File: doc/BRIEF.md
# Bit-Slice Integer ALU

A purely combinational integer arithmetic/logic unit of parameterised width, built as a chain of identical one-bit cells. Each cell receives one bit of each operand, the carry from the cell below, an operand-B inversion control and a "less" input. It returns a result bit and a carry to the cell above. A two-bit operation code picks one of four functions: bitwise AND, bitwise OR, addition/subtraction, or signed set-on-less-than.

Subtraction is A plus the inverted B plus one, requested by raising both the inversion and carry-in controls. Every cell computes a signed-overflow bit and a "set" bit, but only the values from the top cell are used. For the comparison, the corrected sign of A minus B is fed back from the top cell into the "less" input of cell 0. All other cells have their "less" input tied low.

A zero flag reports a result of all zeros. After a subtraction it therefore signals that the operands are equal.

Top module: `aluBitSlice`

## Requirements
- R1: With opSel = 0, result equals opA AND Beff, where Beff is ~opB when invertB = 1 and opB otherwise.
- R2: With opSel = 1, result equals opA OR Beff.
- R3: With opSel = 2, result equals (opA + Beff + carryIn) modulo 2^WIDTH. Subtraction is invertB = 1 with carryIn = 1.
- R4: With opSel = 3, result is 1 when opA < opB as signed two's-complement numbers and 0 otherwise. The invertB and carryIn inputs have no effect in this mode.
- R5: overflow is 1 only with opSel = 2, and only when the true signed value of opA + Beff + carryIn lies outside the WIDTH-bit two's-complement range. It is 0 for every other opSel.
- R6: zero is 1 exactly when every bit of result is 0. A subtraction of equal operands therefore raises zero.
- R7: With opSel = 1, invertB = 1 and opA = 0, result equals the bitwise complement of opB.
- R8: All bit positions use the same cell. The carry runs from cell i to cell i+1, and only cell 0 receives the comparison feedback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| opSel | input | 2 | Operation code: 0 AND, 1 OR, 2 add/subtract, 3 signed set-less-than |
| invertB | input | 1 | Invert operand B before use (ignored for opSel 3) |
| carryIn | input | 1 | Carry into cell 0 (ignored for opSel 3) |
| result | output | WIDTH | Operation result |
| zero | output | 1 | High when result is all zeros |
| overflow | output | 1 | Signed overflow of the add/subtract path |

## Verification
The bench builds two instances of the unit: one at the default width of 32 and one at a width of 8. At 32 bits it checks directed extremes (0, 1, -1, the most positive value and the most negative value) in every pairing, then several thousand constrained-random vectors. The 8-bit instance makes the whole operand space small enough to sweep. Every pair of operands goes through the signed comparison, so every sign and overflow combination of the fed-back subtraction is covered, and a random sweep checks addition, subtraction and overflow at that width.

// File: rtl/aluBitSlicePkg.sv
package aluBitSlicePkg;

  typedef enum logic [1:0] {
    OP_AND   = 2'd0,
    OP_OR    = 2'd1,
    OP_ARITH = 2'd2,
    OP_SLT   = 2'd3
  } aluOp_e;

  // strobes from the control decoder to every cell of the datapath
  typedef struct packed {
    logic selAnd;
    logic selOr;
    logic selSum;
    logic selLess;
    logic invB;
    logic carry0;
    logic ovfEn;
  } sliceCtl_t;

endpackage

// File: rtl/aluSlice.sv
module aluSlice
  import aluBitSlicePkg::*;
(
  input  logic      a,
  input  logic      b,
  input  logic      cIn,
  input  logic      less,
  input  sliceCtl_t ctl,
  output logic      resBit,
  output logic      cOut,
  output logic      ovfBit,
  output logic      setBit
);
  logic bEff;
  logic sumBit;

  assign bEff   = b ^ ctl.invB;
  assign sumBit = a ^ bEff ^ cIn;
  assign cOut   = (a & bEff) | (cIn & (a ^ bEff));

  // meaningful only where this cell holds the sign bit
  assign ovfBit = ~(a ^ bEff) & (sumBit ^ a);
  assign setBit = sumBit ^ ovfBit;

  always_comb begin
    if (ctl.selAnd)      resBit = a & bEff;
    else if (ctl.selOr)  resBit = a | bEff;
    else if (ctl.selSum) resBit = sumBit;
    else                 resBit = less;
  end
endmodule

// File: rtl/aluSliceCtrl.sv
module aluSliceCtrl
  import aluBitSlicePkg::*;
(
  input  logic [1:0] opSel,
  input  logic       invertB,
  input  logic       carryIn,
  output sliceCtl_t  ctl
);
  always_comb begin
    ctl        = '0;
    ctl.invB   = invertB;
    ctl.carry0 = carryIn;
    case (opSel)
      OP_AND:   ctl.selAnd = 1'b1;
      OP_OR:    ctl.selOr  = 1'b1;
      OP_ARITH: begin
        ctl.selSum = 1'b1;
        ctl.ovfEn  = 1'b1;
      end
      default: begin
        // comparison always runs the chain as A - B
        ctl.selLess = 1'b1;
        ctl.invB    = 1'b1;
        ctl.carry0  = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluBitSlicePkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  sliceCtl_t        ctl,
  output logic [WIDTH-1:0] result,
  output logic             ovfTop
);
  localparam int MSB = WIDTH - 1;

  logic             lessBack;
  logic [WIDTH-1:0] unusedOvf;
  logic [WIDTH-1:0] unusedSet;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic cIn, cOut, rBit, oBit, sBit, lessIn;
    if (i == 0) begin : g_lsb
      assign cIn    = ctl.carry0;
      assign lessIn = lessBack;
    end else begin : g_upper
      assign cIn    = g_bit[i-1].cOut;
      assign lessIn = 1'b0;
    end
    aluSlice u_slice (
      .a      (opA[i]),
      .b      (opB[i]),
      .cIn    (cIn),
      .less   (lessIn),
      .ctl    (ctl),
      .resBit (rBit),
      .cOut   (cOut),
      .ovfBit (oBit),
      .setBit (sBit)
    );
    assign result[i]    = rBit;
    assign unusedOvf[i] = oBit;
    assign unusedSet[i] = sBit;
  end

  // sign of A - B from the top cell returns to cell 0 (R8)
  assign lessBack = g_bit[MSB].sBit;
  assign ovfTop   = g_bit[MSB].oBit;

  always_comb begin
    // R4: only cell 0 may carry the comparison outcome
    a_r4_set_upper_clear: assert (!ctl.selLess || (result >> 1) == '0)
      else $error("set mode left upper result bits nonzero");
    // R8: cell 0 carry-in follows the strobe
    a_r8_carry_origin: assert (g_bit[0].cIn == ctl.carry0)
      else $error("cell 0 carry-in mismatch");
  end
endmodule

// File: rtl/aluBitSlice.sv
module aluBitSlice
  import aluBitSlicePkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [1:0]       opSel,
  input  logic             invertB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             overflow
);
  localparam int MSB = WIDTH - 1;

  sliceCtl_t ctl;
  logic      ovfTop;

  aluSliceCtrl u_ctrl (
    .opSel   (opSel),
    .invertB (invertB),
    .carryIn (carryIn),
    .ctl     (ctl)
  );

  aluDatapath #(.WIDTH(WIDTH)) u_dp (
    .opA    (opA),
    .opB    (opB),
    .ctl    (ctl),
    .result (result),
    .ovfTop (ovfTop)
  );

  assign zero     = ~|result;
  assign overflow = ovfTop & ctl.ovfEn;

  always_comb begin
    a_r1_and_within: assert (opSel != 2'd0 || (result & ~opA) == '0)
      else $error("AND result has bits outside opA");
    a_r2_or_covers: assert (opSel != 2'd1 || (result & opA) == opA)
      else $error("OR result drops bits of opA");
    a_r4_set_signed: assert (opSel != 2'd3 || result[0] == ($signed(opA) < $signed(opB)))
      else $error("set result disagrees with signed compare");
    a_r5_ovf_signs: assert (!overflow ||
                            (opSel == 2'd2 && opA[MSB] == (opB[MSB] ^ invertB) && result[MSB] != opA[MSB]))
      else $error("overflow raised without sign conflict");
    a_r6_zero_equal: assert (!(opSel == 2'd2 && invertB && carryIn && zero) || opA == opB)
      else $error("zero after subtract with unequal operands");
  end
endmodule

// File: tb/aluBitSlice_test.sv
module aluBitSlice_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] a, b, res;
  logic [1:0]  op;
  logic        inv, cin, zf, of;

  logic [7:0]  na, nb, nres;
  logic [1:0]  nop;
  logic        ninv, ncin, nzf, nof;

  aluBitSlice #(.WIDTH(32)) uut (
    .opA(a), .opB(b), .opSel(op), .invertB(inv), .carryIn(cin),
    .result(res), .zero(zf), .overflow(of));

  aluBitSlice #(.WIDTH(8)) uutNarrow (
    .opA(na), .opB(nb), .opSel(nop), .invertB(ninv), .carryIn(ncin),
    .result(nres), .zero(nzf), .overflow(nof));

  function automatic logic [31:0] expRes(logic [1:0] o, logic [31:0] x, logic [31:0] y,
                                         logic iv, logic ci);
    logic [31:0] ye = iv ? ~y : y;
    case (o)
      2'd0:    return x & ye;
      2'd1:    return x | ye;
      2'd2:    return x + ye + 32'(ci);
      default: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
    endcase
  endfunction

  function automatic logic expOvf(logic [1:0] o, logic [31:0] x, logic [31:0] y,
                                  logic iv, logic ci);
    logic [31:0] ye = iv ? ~y : y;
    longint s;
    if (o != 2'd2) return 1'b0;
    s = longint'($signed(x)) + longint'($signed(ye)) + longint'(ci);
    return (s > 64'sd2147483647) || (s < -64'sd2147483648);
  endfunction

  task automatic cmp(string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic run32(logic [1:0] o, logic [31:0] x, logic [31:0] y, logic iv, logic ci);
    logic [31:0] e;
    string t;
    @(negedge clk);
    op = o; a = x; b = y; inv = iv; cin = ci;
    #2;
    e = expRes(o, x, y, iv, ci);
    t = (o == 2'd0) ? "R1" : (o == 2'd1) ? "R2" : (o == 2'd2) ? "R3" : "R4";
    cmp(t, "result", res, e);
    cmp("R6", "zero", 32'(zf), 32'(e == 32'd0));
    cmp("R5", "overflow", 32'(of), 32'(expOvf(o, x, y, iv, ci)));
  endtask

  function automatic logic [31:0] pick();
    case ($urandom % 8)
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'h7FFF_FFFF;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    logic [31:0] corners [6];
    corners = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 32'h1234_5678};
    void'($urandom(32'd20240611));
    op = 0; a = 0; b = 0; inv = 0; cin = 0;
    nop = 0; na = 0; nb = 0; ninv = 0; ncin = 0;

    // quiet state: all-zero inputs give zero result, zero flag, no overflow
    @(negedge clk); #2;
    cmp("R1", "idle result", res, 32'd0);
    cmp("R6", "idle zero", 32'(zf), 32'd1);
    cmp("R5", "idle overflow", 32'(of), 32'd0);

    // directed extremes in every pairing
    foreach (corners[i]) foreach (corners[j]) begin
      run32(2'd0, corners[i], corners[j], 1'b0, 1'b0);
      run32(2'd1, corners[i], corners[j], 1'b0, 1'b0);
      run32(2'd2, corners[i], corners[j], 1'b0, 1'b0);
      run32(2'd2, corners[i], corners[j], 1'b1, 1'b1);
      run32(2'd3, corners[i], corners[j], 1'(i), 1'(j));
    end

    // R7: complement through the OR path
    for (int k = 0; k < 20; k++) begin
      logic [31:0] y = pick();
      @(negedge clk);
      op = 2'd1; a = 32'd0; b = y; inv = 1'b1; cin = 1'b0;
      #2;
      cmp("R7", "complement", res, ~y);
    end

    // R6: equal operands subtract to zero
    for (int k = 0; k < 50; k++) begin
      logic [31:0] x = pick();
      run32(2'd2, x, x, 1'b1, 1'b1);
    end

    // R4: set ignores the inversion and carry controls
    for (int k = 0; k < 200; k++)
      run32(2'd3, pick(), pick(), 1'($urandom), 1'($urandom));

    // constrained random over all operations
    for (int k = 0; k < 3000; k++)
      run32(2'($urandom), pick(), pick(), 1'($urandom), 1'($urandom));

    // R8 / R4: full sweep of the signed comparison on the 8-bit chain
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        @(negedge clk);
        nop = 2'd3; na = 8'(x); nb = 8'(y); ninv = 1'(x); ncin = 1'(y);
        #2;
        cmp("R8", "narrow set", 32'(nres), ($signed(8'(x)) < $signed(8'(y))) ? 32'd1 : 32'd0);
      end
    end

    // R3 / R5 at 8 bits
    for (int k = 0; k < 2000; k++) begin
      logic [7:0] x = 8'($urandom);
      logic [7:0] y = 8'($urandom);
      logic iv = 1'($urandom);
      logic ci = 1'($urandom);
      logic [7:0] ye = iv ? ~y : y;
      int s = int'($signed(x)) + int'($signed(ye)) + int'(ci);
      @(negedge clk);
      nop = 2'd2; na = x; nb = y; ninv = iv; ncin = ci;
      #2;
      cmp("R3", "narrow sum", 32'(nres), 32'(8'(x + ye + 8'(ci))));
      cmp("R5", "narrow overflow", 32'(nof), 32'((s > 127) || (s < -128)));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule